// File: doc/BRIEF.md
# Programmable 16-bit Reload Down-Counter

This block is a down-counting timer with a software-programmed start value. Software writes a start value into a reload register, then writes the control register with the enable and trigger bits set. That write copies the reload value into the counter and starts it. From then on the counter steps down by one on every clock in which the count-tick input is high. When the counter steps down from zero, an underflow has happened. A sticky status flag is set and, if enabled, the interrupt line rises.

A policy bit chooses what happens on underflow. In one-shot policy the counter stops and waits for a new trigger. In periodic policy it reloads and carries on. The timer pin follows the policy. In one-shot policy it drives a pulse that is active for the whole count, and its polarity is selectable. In periodic policy it inverts on each underflow, starting from a selectable level.

Top module: `reload_down_timer`

## Requirements
- R1: After reset, every register reads 0, the pin is low and the interrupt is low.
- R2: Register map. Address 0 is control. Address 1 is the reload value and can be read and written. Address 2 is the current count and is read-only. Address 3 reads 0. Read data is registered and shows the addressed register one clock after the address is applied.
- R3: The control register has the following fields: bit 0 enable, bit 1 trigger, bit 2 underflow flag, bit 3 interrupt enable, bit 4 policy (1 = periodic), bit 5 idle level, bits 8:6 mode. A control write that leaves enable at 1 and has trigger 1 and mode 000 does two things in the same clock: it loads the reload value into the counter and starts counting. A trigger is ignored when enable is 0 or when mode is not 000. The trigger bit always reads 0.
- R4: While the timer is running, the count drops by exactly one on each clock with the tick input high. The count holds on each clock with the tick input low.
- R5: An underflow sets the flag. The flag is cleared only by writing 0 to bit 2. Writing 1 to bit 2 leaves it unchanged. If an underflow and a clear fall in the same clock, the flag ends up set.
- R6: The interrupt output is the registered AND of the flag and the interrupt enable, delayed by one clock.
- R7: In one-shot policy, an underflow stops the counter with the count at 0xFFFF. Further ticks leave it there until the next trigger.
- R8: In periodic policy, an underflow loads the reload value and counting continues.
- R9: In one-shot policy, the pin sits at the idle level while stopped. While running it sits at the inverse of the idle level.
- R10: In periodic policy, the pin equals the idle level at start and inverts on every underflow.
- R11: Writing enable to 0 stops counting in that same clock, holds the count, and returns the pin to the idle level.
- R12: While enable is already 1, a control write does not change the mode field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| cnt_tick | input | 1 | Count-clock enable |
| tmr_pin | output | 1 | Timer output wave |
| tmr_irq | output | 1 | Interrupt request, level |

## Verification
The assertions assume that the tick input and the write strobe are synchronous to the clock and stable around its edge. They also assume that a write and an underflow can fall in the same clock, and they check that the hardware set of the flag wins. The stimulus changes every input half a period away from the rising edge. It keeps the tick input low during register reads unless a test wants a tick and a write in the same clock. Only the documented mode value 000 is used to start the timer. The one non-zero mode is used only to show that it blocks a trigger.

// File: rtl/rdt_pkg.sv
package rdt_pkg;
  localparam int ADDR_CTRL   = 0;
  localparam int ADDR_RELOAD = 1;
  localparam int ADDR_COUNT  = 2;

  localparam int B_EN    = 0;
  localparam int B_TRG   = 1;
  localparam int B_UF    = 2;
  localparam int B_IRQEN = 3;
  localparam int B_RSEL  = 4;
  localparam int B_LVL   = 5;
  localparam int B_MODE  = 6;
  localparam int MODE_W  = 3;

  localparam logic [MODE_W-1:0] MODE_SW = '0;
endpackage

// File: rtl/rdt_regs.sv
module rdt_regs
  import rdt_pkg::*;
#(
  parameter int W  = 16,
  parameter int AW = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [AW-1:0]     addr,
  input  logic [W-1:0]      wdata,
  input  logic              uf_evt,
  input  logic [W-1:0]      count,
  output logic [W-1:0]      rdata,
  output logic              en_nx,
  output logic              rsel_nx,
  output logic              lvl_nx,
  output logic              start,
  output logic [W-1:0]      reload_q,
  output logic              en_q,
  output logic              lvl_q,
  output logic              flag_q,
  output logic              irqen_q,
  output logic [MODE_W-1:0] mode_q,
  output logic              irq
);
  logic              ctrl_wr, reload_wr;
  logic              rsel_q;
  logic              irqen_nx, flag_nx;
  logic [MODE_W-1:0] mode_nx;
  logic [W-1:0]      ctrl_view;

  assign ctrl_wr   = wr && (addr == AW'(ADDR_CTRL));
  assign reload_wr = wr && (addr == AW'(ADDR_RELOAD));

  always_comb begin
    en_nx    = ctrl_wr ? wdata[B_EN]    : en_q;
    irqen_nx = ctrl_wr ? wdata[B_IRQEN] : irqen_q;
    rsel_nx  = ctrl_wr ? wdata[B_RSEL]  : rsel_q;
    lvl_nx   = ctrl_wr ? wdata[B_LVL]   : lvl_q;
    mode_nx  = (ctrl_wr && !en_q) ? wdata[B_MODE +: MODE_W] : mode_q;
    start    = ctrl_wr && wdata[B_TRG] && en_nx && (mode_nx == MODE_SW);
    if (uf_evt)
      flag_nx = 1'b1;
    else if (ctrl_wr && !wdata[B_UF])
      flag_nx = 1'b0;
    else
      flag_nx = flag_q;
  end

  always_comb begin
    ctrl_view                   = '0;
    ctrl_view[B_EN]             = en_q;
    ctrl_view[B_UF]             = flag_q;
    ctrl_view[B_IRQEN]          = irqen_q;
    ctrl_view[B_RSEL]           = rsel_q;
    ctrl_view[B_LVL]            = lvl_q;
    ctrl_view[B_MODE +: MODE_W] = mode_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      irqen_q  <= 1'b0;
      rsel_q   <= 1'b0;
      lvl_q    <= 1'b0;
      mode_q   <= '0;
      flag_q   <= 1'b0;
      reload_q <= '0;
      irq      <= 1'b0;
      rdata    <= '0;
    end else begin
      en_q    <= en_nx;
      irqen_q <= irqen_nx;
      rsel_q  <= rsel_nx;
      lvl_q   <= lvl_nx;
      mode_q  <= mode_nx;
      flag_q  <= flag_nx;
      irq     <= flag_q && irqen_q;
      if (reload_wr)
        reload_q <= wdata;
      case (addr)
        AW'(ADDR_CTRL):   rdata <= ctrl_view;
        AW'(ADDR_RELOAD): rdata <= reload_q;
        AW'(ADDR_COUNT):  rdata <= count;
        default:          rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/rdt_count_core.sv
module rdt_count_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         en_nx,
  input  logic         tick,
  input  logic         rsel_nx,
  input  logic [W-1:0] reload_q,
  output logic [W-1:0] count_q,
  output logic         run_q,
  output logic         uf_evt
);
  localparam logic [W-1:0] ALL_ONES = '1;

  assign uf_evt = run_q && en_nx && tick && !start && (count_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      run_q   <= 1'b0;
    end else if (start) begin
      count_q <= reload_q;
      run_q   <= 1'b1;
    end else if (!en_nx) begin
      run_q <= 1'b0;
    end else if (run_q && tick) begin
      if (uf_evt) begin
        if (rsel_nx) begin
          count_q <= reload_q;
        end else begin
          count_q <= ALL_ONES;
          run_q   <= 1'b0;
        end
      end else begin
        count_q <= count_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/rdt_wave_out.sv
module rdt_wave_out (
  input  logic clk,
  input  logic rst,
  input  logic en_nx,
  input  logic start,
  input  logic uf_evt,
  input  logic run_q,
  input  logic rsel_nx,
  input  logic lvl_nx,
  output logic pin_q
);
  always_ff @(posedge clk) begin
    if (rst)
      pin_q <= 1'b0;
    else if (!en_nx)
      pin_q <= lvl_nx;
    else if (start)
      pin_q <= rsel_nx ? lvl_nx : !lvl_nx;
    else if (uf_evt)
      pin_q <= rsel_nx ? !pin_q : lvl_nx;
    else if (!run_q)
      pin_q <= lvl_nx;
  end
endmodule

// File: rtl/reload_down_timer.sv
module reload_down_timer
  import rdt_pkg::*;
#(
  parameter int W  = 16,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic          cnt_tick,
  output logic          tmr_pin,
  output logic          tmr_irq
);
  logic              en_nx, rsel_nx, lvl_nx, start;
  logic              en_q, lvl_q, flag_q, irqen_q;
  logic [MODE_W-1:0] mode_q;
  logic [W-1:0]      reload_q, count_q;
  logic              run_q, uf_evt;

  rdt_regs #(.W(W), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .uf_evt(uf_evt), .count(count_q), .rdata(bus_rdata),
    .en_nx(en_nx), .rsel_nx(rsel_nx), .lvl_nx(lvl_nx), .start(start),
    .reload_q(reload_q), .en_q(en_q), .lvl_q(lvl_q), .flag_q(flag_q),
    .irqen_q(irqen_q), .mode_q(mode_q), .irq(tmr_irq)
  );

  rdt_count_core #(.W(W)) u_core (
    .clk(clk), .rst(rst), .start(start), .en_nx(en_nx), .tick(cnt_tick),
    .rsel_nx(rsel_nx), .reload_q(reload_q), .count_q(count_q),
    .run_q(run_q), .uf_evt(uf_evt)
  );

  rdt_wave_out u_wave (
    .clk(clk), .rst(rst), .en_nx(en_nx), .start(start), .uf_evt(uf_evt),
    .run_q(run_q), .rsel_nx(rsel_nx), .lvl_nx(lvl_nx), .pin_q(tmr_pin)
  );
endmodule

// File: rtl/rdt_checker.sv
module rdt_checker #(
  parameter int W  = 16,
  parameter int AW = 2,
  parameter int MW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] bus_addr,
  input logic [W-1:0]  bus_rdata,
  input logic          cnt_tick,
  input logic          tmr_pin,
  input logic          tmr_irq,
  input logic          uf_evt,
  input logic          start,
  input logic          en_nx,
  input logic          en_q,
  input logic          rsel_nx,
  input logic          run_q,
  input logic [W-1:0]  count_q,
  input logic [W-1:0]  reload_q,
  input logic          lvl_q,
  input logic          flag_q,
  input logic          irqen_q,
  input logic [MW-1:0] mode_q
);
  AST_TRIG_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_addr) == '0) |-> !bus_rdata[1]); // R3
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (run_q && cnt_tick && en_nx && !start && count_q != '0) |=> (count_q == $past(count_q) - 1'b1)); // R4
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
    uf_evt |=> flag_q); // R5
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (rst)
    $rose(tmr_irq) |-> $past(flag_q && irqen_q)); // R6
  AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (rst)
    (uf_evt && !rsel_nx) |=> (!run_q && count_q == {W{1'b1}})); // R7
  AST_RELOAD_CONT: assert property (@(posedge clk) disable iff (rst)
    (uf_evt && rsel_nx) |=> (run_q && count_q == $past(reload_q))); // R8
  AST_PIN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !run_q |-> (tmr_pin == lvl_q)); // R9
  AST_HALT_NOW: assert property (@(posedge clk) disable iff (rst)
    !en_nx |=> !run_q); // R11
  AST_MODE_LOCK: assert property (@(posedge clk) disable iff (rst)
    $past(en_q) |-> $stable(mode_q)); // R12
endmodule

bind reload_down_timer rdt_checker #(.W(W), .AW(AW), .MW(rdt_pkg::MODE_W)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .cnt_tick(cnt_tick), .tmr_pin(tmr_pin), .tmr_irq(tmr_irq),
  .uf_evt(uf_evt), .start(start), .en_nx(en_nx), .en_q(en_q),
  .rsel_nx(rsel_nx), .run_q(run_q), .count_q(count_q), .reload_q(reload_q),
  .lvl_q(lvl_q), .flag_q(flag_q), .irqen_q(irqen_q), .mode_q(mode_q)
);

// File: tb/tb_reload_down_timer.sv
`timescale 1ns/1ps
module tb_reload_down_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        cnt_tick = 1'b0;
  logic        tmr_pin, tmr_irq;
  int          checks = 0;
  int          failures = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  reload_down_timer dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_tick(cnt_tick),
    .tmr_pin(tmr_pin), .tmr_irq(tmr_irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    cnt_tick = 1'b1;
    repeat (n) @(negedge clk);
    cnt_tick = 1'b0;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    rd(2'd0, v); chk("R1 ctrl", v, 16'h0);
    rd(2'd1, v); chk("R1 reload", v, 16'h0);
    rd(2'd2, v); chk("R1 count", v, 16'h0);
    chk("R1 pin", {15'd0, tmr_pin}, 16'h0);
    chk("R1 irq", {15'd0, tmr_irq}, 16'h0);
  endtask

  task automatic t_regmap;
    logic [15:0] v;
    wr(2'd1, 16'hA5C3);
    rd(2'd1, v); chk("R2 reload readback", v, 16'hA5C3);
    wr(2'd2, 16'h1234);
    rd(2'd2, v); chk("R2 count read-only", v, 16'h0);
    rd(2'd3, v); chk("R2 addr3 zero", v, 16'h0);
  endtask

  task automatic t_oneshot;
    logic [15:0] v;
    wr(2'd1, 16'd5);
    wr(2'd0, 16'h000B);
    rd(2'd2, v); chk("R3 trigger loads reload", v, 16'd5);
    rd(2'd0, v); chk("R3 trigger reads 0", v, 16'h0009);
    chk("R9 pin active while running", {15'd0, tmr_pin}, 16'h1);
    ticks(3);
    rd(2'd2, v); chk("R4 three ticks", v, 16'd2);
    ticks(3);
    chk("R9 pin idle after stop", {15'd0, tmr_pin}, 16'h0);
    rd(2'd2, v); chk("R7 count at FFFF", v, 16'hFFFF);
    chk("R6 irq raised", {15'd0, tmr_irq}, 16'h1);
    rd(2'd0, v); chk("R5 flag set", v, 16'h000D);
    ticks(4);
    rd(2'd2, v); chk("R7 stays stopped", v, 16'hFFFF);
  endtask

  task automatic t_flag_clear;
    logic [15:0] v;
    wr(2'd0, 16'h000D);
    rd(2'd0, v); chk("R5 write 1 keeps flag", v, 16'h000D);
    wr(2'd0, 16'h0009);
    chk("R6 irq one clock late", {15'd0, tmr_irq}, 16'h1);
    rd(2'd0, v); chk("R5 write 0 clears flag", v, 16'h0009);
    chk("R6 irq dropped", {15'd0, tmr_irq}, 16'h0);
  endtask

  task automatic t_ignored_triggers;
    logic [15:0] v;
    wr(2'd1, 16'd7);
    wr(2'd0, 16'h0000);
    wr(2'd0, 16'h0002);
    rd(2'd2, v); chk("R3 trigger ignored when disabled", v, 16'hFFFF);
    wr(2'd0, 16'h0043);
    rd(2'd2, v); chk("R3 trigger ignored in mode 1", v, 16'hFFFF);
    wr(2'd0, 16'h0003);
    rd(2'd0, v); chk("R12 mode locked while enabled", v, 16'h0041);
    rd(2'd2, v); chk("R12 no start with locked mode", v, 16'hFFFF);
    wr(2'd0, 16'h0000);
    wr(2'd0, 16'h0000);
    rd(2'd0, v); chk("R12 mode writable when disabled", v, 16'h0000);
  endtask

  task automatic t_periodic;
    logic [15:0] v;
    wr(2'd1, 16'd2);
    wr(2'd0, 16'h0033);
    chk("R10 start level", {15'd0, tmr_pin}, 16'h1);
    ticks(3);
    chk("R10 first toggle", {15'd0, tmr_pin}, 16'h0);
    rd(2'd2, v); chk("R8 reloaded", v, 16'd2);
    rd(2'd0, v); chk("R5 flag in periodic", v, 16'h0035);
    ticks(3);
    chk("R10 second toggle", {15'd0, tmr_pin}, 16'h1);
    ticks(3);
    chk("R10 third toggle", {15'd0, tmr_pin}, 16'h0);
    ticks(1);
    rd(2'd2, v); chk("R8 keeps counting", v, 16'd1);
    wr(2'd0, 16'h0030);
    chk("R11 pin to idle level", {15'd0, tmr_pin}, 16'h1);
    ticks(3);
    rd(2'd2, v); chk("R11 count held", v, 16'd1);
  endtask

  task automatic t_active_low_and_race;
    logic [15:0] v;
    wr(2'd1, 16'd0);
    wr(2'd0, 16'h0023);
    chk("R9 active-low pulse", {15'd0, tmr_pin}, 16'h0);
    ticks(1);
    chk("R9 back to idle high", {15'd0, tmr_pin}, 16'h1);
    rd(2'd2, v); chk("R7 zero reload underflows", v, 16'hFFFF);
    wr(2'd0, 16'h0021);
    rd(2'd0, v); chk("R5 flag cleared", v, 16'h0021);
    wr(2'd0, 16'h0023);
    cnt_tick = 1'b1;
    wr(2'd0, 16'h0021);
    cnt_tick = 1'b0;
    rd(2'd0, v); chk("R5 set wins over clear", v, 16'h0025);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regmap();
    t_oneshot();
    t_flag_clear();
    t_ignored_triggers();
    t_periodic();
    t_active_low_and_race();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule